// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block expands one accepted column command into the ordered column addresses of one DRAM burst. A start strobe captures the column address, a 3-bit burst-length code and a burst-type bit taken from a mode-register image. From the next clock the block emits one column address per cycle with a valid flag, and marks the final beat with a last flag.

Each burst stays inside an aligned block of columns as wide as the burst length. The low column bits give the first beat. Later beats either count upward and wrap inside the block (sequential type), or are formed by XOR of the start offset with the beat index (interleaved type). The bits above the block offset never change during a burst. Reserved length codes produce no beats and raise an illegal-mode flag instead. A controller uses the block by pulsing the strobe whenever busy is low and consuming the addresses while valid is high.

Top module: `burst_col_seq`

## Requirements
- R1: An accepted start with length code 3'b001, 3'b010 or 3'b011 gives exactly 2, 4 or 8 beats. Valid is high on consecutive cycles, starting the cycle after the accepting clock edge.
- R2: The last flag is high on the final beat of a burst and low on every other cycle.
- R3: On every beat, column bits above bit 0 (2 beats), bit 1 (4 beats) or bit 2 (8 beats) equal those of the captured start column. There is no carry out of the block.
- R4: With the type bit at 0 (sequential), the low bits of beat n equal (start offset + n) modulo the burst length. For example, 8 beats from offset 5 give 5,6,7,0,1,2,3,4.
- R5: With the type bit at 1 (interleaved), the low bits of beat n equal start offset XOR n. For example, 8 beats from offset 5 give 5,4,7,6,1,0,3,2.
- R6: An accepted start with any other length code sets the illegal-mode flag from the next cycle and issues no beats. The flag holds until the next accepted start, which updates it.
- R7: A start strobe is accepted only while busy is low. One that arrives while busy is ignored, including on the last beat. A start on the first cycle after the last beat is accepted.
- R8: Busy is high exactly on the cycles that carry beats.
- R9: During and after reset, busy, valid, last and the illegal-mode flag are low.
- R10: Column, length and type inputs are sampled only at the accepting edge. Changes to them during a burst do not alter its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one burst |
| col_i | input | COL_W | Start column address |
| len_code_i | input | 3 | Burst-length code from the mode image |
| ilv_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| beat_valid_o | output | 1 | Beat address valid |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_last_o | output | 1 | Final beat of the burst |
| busy_o | output | 1 | Burst in progress |
| mode_err_o | output | 1 | Last accepted start carried a reserved length code |

## Verification
The bench starts bursts from offsets near the block boundary and from a column whose upper bits are all ones. A design that carried the wrap into the upper bits would show a changed block address there. Offset 5 in eight-beat mode separates the two orderings: mixing up add and XOR gives 5,6,7... where 5,4,7... is expected. The bench toggles the strobe and the inputs through an entire burst, including its last beat, so a design that re-samples its inputs or restarts mid-burst produces wrong addresses or an extra beat. Reserved codes 000, 100 and 111 must leave valid low, and back-to-back bursts confirm that the flag is cleared and that there is no lost cycle or double beat at the seam.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   // Width of the in-block offset for the largest burst (8 beats).
   localparam int OFS_W = 3;

   localparam logic [2:0] LEN_CODE_2 = 3'b001;
   localparam logic [2:0] LEN_CODE_4 = 3'b010;
   localparam logic [2:0] LEN_CODE_8 = 3'b011;

   typedef struct packed {
      logic             legal;
      logic [OFS_W-1:0] span_m1;   // beats minus one, doubles as offset mask
   } len_dec_t;

   function automatic len_dec_t decode_len(input logic [2:0] code);
      len_dec_t d;
      d.legal   = 1'b1;
      d.span_m1 = '0;
      case (code)
         LEN_CODE_2: d.span_m1 = 3'b001;
         LEN_CODE_4: d.span_m1 = 3'b011;
         LEN_CODE_8: d.span_m1 = 3'b111;
         default:    d.legal   = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
   import burst_col_pkg::*;
(
   input  logic [2:0]       len_code_i,
   output logic             legal_o,
   output logic [OFS_W-1:0] span_m1_o
);
   len_dec_t dec;

   always_comb begin
      dec       = decode_len(len_code_i);
      legal_o   = dec.legal;
      span_m1_o = dec.span_m1;
   end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
   import burst_col_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [OFS_W-1:0] span_m1_i,
   output logic             active_o,
   output logic [OFS_W-1:0] idx_o,
   output logic [OFS_W-1:0] span_q_o,
   output logic             last_o
);
   logic             active_q;
   logic [OFS_W-1:0] idx_q;
   logic [OFS_W-1:0] span_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         span_q   <= '0;
      end else if (load_i) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         span_q   <= span_m1_i;
      end else if (active_q) begin
         if (idx_q == span_q) begin
            active_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign idx_o    = idx_q;
   assign span_q_o = span_q;
   assign last_o   = active_q && (idx_q == span_q);
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
   import burst_col_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] base_i,
   input  logic             ilv_i,
   input  logic [OFS_W-1:0] mask_i,
   input  logic [OFS_W-1:0] idx_i,
   output logic [COL_W-1:0] col_o
);
   logic [OFS_W-1:0] ofs_seq;
   logic [OFS_W-1:0] ofs_ilv;
   logic [OFS_W-1:0] ofs;

   assign ofs_seq = base_i[OFS_W-1:0] + idx_i;   // wraps mod 8, masked below
   assign ofs_ilv = base_i[OFS_W-1:0] ^ idx_i;
   assign ofs     = ilv_i ? ofs_ilv : ofs_seq;

   for (genvar b = 0; b < OFS_W; b++) begin : g_ofs_bit
      assign col_o[b] = mask_i[b] ? ofs[b] : base_i[b];
   end

   if (COL_W > OFS_W) begin : g_upper
      assign col_o[COL_W-1:OFS_W] = base_i[COL_W-1:OFS_W];
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_col_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [2:0]       len_code_i,
   input  logic             ilv_i,
   output logic             beat_valid_o,
   output logic [COL_W-1:0] beat_col_o,
   output logic             beat_last_o,
   output logic             busy_o,
   output logic             mode_err_o
);
   initial begin
      assert (COL_W >= OFS_W)
         else $fatal(1, "burst_col_seq: COL_W must be at least %0d", OFS_W);
   end

   logic             legal;
   logic [OFS_W-1:0] span_m1;
   logic             active;
   logic [OFS_W-1:0] idx;
   logic [OFS_W-1:0] span_q;
   logic             last;
   logic             accept;
   logic [COL_W-1:0] col_q;
   logic             ilv_q;
   logic             err_q;

   assign accept = start_i && !active;

   bcs_mode_decode u_dec (
      .len_code_i (len_code_i),
      .legal_o    (legal),
      .span_m1_o  (span_m1)
   );

   bcs_beat_ctr u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept && legal),
      .span_m1_i (span_m1),
      .active_o  (active),
      .idx_o     (idx),
      .span_q_o  (span_q),
      .last_o    (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         ilv_q <= 1'b0;
         err_q <= 1'b0;
      end else if (accept) begin
         col_q <= col_i;
         ilv_q <= ilv_i;
         err_q <= !legal;
      end
   end

   bcs_addr_gen #(.COL_W(COL_W)) u_gen (
      .base_i (col_q),
      .ilv_i  (ilv_q),
      .mask_i (span_q),
      .idx_i  (idx),
      .col_o  (beat_col_o)
   );

   assign beat_valid_o = active;
   assign beat_last_o  = last;
   assign busy_o       = active;
   assign mode_err_o   = err_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [2:0]       len_code_i,
   input logic             beat_valid_o,
   input logic [COL_W-1:0] beat_col_o,
   input logic             beat_last_o,
   input logic             busy_o,
   input logic             mode_err_o
);
   logic code_ok;
   assign code_ok = (len_code_i == 3'b001) || (len_code_i == 3'b010) ||
                    (len_code_i == 3'b011);

   // R1
   legal_start_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && code_ok |=> beat_valid_o && !mode_err_o);

   // R6
   illegal_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && !code_ok |=> mode_err_o && !beat_valid_o);

   // R2
   last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last_o |-> beat_valid_o);

   // R8
   last_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last_o |=> !busy_o);

   // R3
   block_upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid_o && !beat_last_o |=> $stable(beat_col_o[COL_W-1:3]));

   // R7
   busy_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(mode_err_o));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .len_code_i   (len_code_i),
   .beat_valid_o (beat_valid_o),
   .beat_col_o   (beat_col_o),
   .beat_last_o  (beat_last_o),
   .busy_o       (busy_o),
   .mode_err_o   (mode_err_o)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] col_i = '0;
   logic [2:0]       len_code_i = 3'b000;
   logic             ilv_i = 1'b0;
   logic             beat_valid_o;
   logic [COL_W-1:0] beat_col_o;
   logic             beat_last_o;
   logic             busy_o;
   logic             mode_err_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .col_i        (col_i),
      .len_code_i   (len_code_i),
      .ilv_i        (ilv_i),
      .beat_valid_o (beat_valid_o),
      .beat_col_o   (beat_col_o),
      .beat_last_o  (beat_last_o),
      .busy_o       (busy_o),
      .mode_err_o   (mode_err_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive a start at the current negedge and check every beat.
   // With junk set, the strobe stays high with different inputs for the whole burst.
   task automatic run_burst(input logic [COL_W-1:0] col, input logic [2:0] code,
                            input logic ilv, input bit junk);
      int bl;
      logic [COL_W-1:0] msk;
      logic [COL_W-1:0] exp;
      logic [COL_W-1:0] lo;
      bl  = (code == 3'b001) ? 2 : (code == 3'b010) ? 4 : 8;
      msk = COL_W'(bl - 1);
      start_i = 1'b1; col_i = col; len_code_i = code; ilv_i = ilv;
      @(posedge clk);
      for (int n = 0; n < bl; n++) begin
         @(negedge clk);
         if (junk) begin
            start_i = 1'b1; col_i = ~col; len_code_i = 3'b001; ilv_i = ~ilv;
         end else begin
            start_i = 1'b0;
         end
         if (ilv) lo = (col & msk) ^ COL_W'(n);
         else     lo = ((col & msk) + COL_W'(n)) & msk;
         exp = (col & ~msk) | lo;
         chk("R1 beat valid", beat_valid_o, 1);
         chk("R8 busy during beat", busy_o, 1);
         chk("R2 last flag", beat_last_o, (n == bl - 1));
         chk("R3 block bits fixed", beat_col_o & ~msk, col & ~msk);
         chk(ilv ? "R5 interleaved order" : "R4 sequential order", beat_col_o, exp);
         if (n == 0) chk("R6 flag cleared by legal start", mode_err_o, 0);
         if (junk) chk("R10 R7 inputs ignored mid-burst", beat_col_o, exp);
      end
      @(negedge clk);
      start_i = 1'b0;
      chk("R8 idle after burst", busy_o, 0);
      chk("R1 no extra beat", beat_valid_o, 0);
      chk("R2 last low when idle", beat_last_o, 0);
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 busy in reset", busy_o, 0);
      chk("R9 valid in reset", beat_valid_o, 0);
      chk("R9 err in reset", mode_err_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 busy after reset", busy_o, 0);
      chk("R9 valid after reset", beat_valid_o, 0);
      chk("R9 last after reset", beat_last_o, 0);
   endtask

   task automatic t_eight_beat_orders();
      run_burst(10'h1A5, 3'b011, 1'b0, 1'b0);
      run_burst(10'h1A5, 3'b011, 1'b1, 1'b0);
      run_burst(10'h0F8, 3'b011, 1'b1, 1'b0);
   endtask

   task automatic t_short_bursts();
      run_burst(10'h2B3, 3'b010, 1'b0, 1'b0);
      run_burst(10'h2B2, 3'b010, 1'b1, 1'b0);
      run_burst(10'h2B1, 3'b001, 1'b0, 1'b0);
      run_burst(10'h2B1, 3'b001, 1'b1, 1'b0);
   endtask

   task automatic t_top_column();
      run_burst(10'h3FF, 3'b011, 1'b0, 1'b0);
      run_burst(10'h3FF, 3'b010, 1'b0, 1'b0);
      run_burst(10'h3FE, 3'b001, 1'b0, 1'b0);
   endtask

   task automatic t_illegal_codes();
      logic [2:0] bad [3] = '{3'b000, 3'b100, 3'b111};
      foreach (bad[i]) begin
         start_i = 1'b1; col_i = 10'h155; len_code_i = bad[i]; ilv_i = 1'b0;
         @(negedge clk);
         start_i = 1'b0;
         chk("R6 err raised", mode_err_o, 1);
         chk("R6 no beat", beat_valid_o, 0);
         chk("R6 not busy", busy_o, 0);
         repeat (3) begin
            @(negedge clk);
            chk("R6 still no beat", beat_valid_o, 0);
            chk("R6 err held", mode_err_o, 1);
         end
      end
      run_burst(10'h155, 3'b011, 1'b0, 1'b0);
   endtask

   task automatic t_busy_ignored();
      run_burst(10'h0C6, 3'b011, 1'b0, 1'b1);
      run_burst(10'h0C6, 3'b010, 1'b1, 1'b1);
      @(negedge clk);
      chk("R7 no burst from ignored strobe", beat_valid_o, 0);
   endtask

   task automatic t_back_to_back();
      run_burst(10'h211, 3'b001, 1'b1, 1'b0);
      run_burst(10'h217, 3'b011, 1'b1, 1'b0);
      run_burst(10'h21A, 3'b010, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset_state();
      t_eight_beat_orders();
      t_short_bursts();
      t_top_column();
      t_illegal_codes();
      t_busy_ignored();
      t_back_to_back();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule